// File: doc/BRIEF.md
# Parallel Bus Command Sequencer

This block is the timing engine for an external parallel memory bus. It does not hardwire the waveform of a bus cycle. Each access is built from a run of segment words held in a shared table. A segment word gives the segment's length in system clocks and sets everything the pins carry during that segment: the chip-select level, the clock gate, eight control line levels, and for each of the four byte groups of the 32-bit DQ bus three things. These are whether the group carries address or data, whether it is driven or sampled, and which internal byte feeds it.

Four chip selects share the table. Each chip select owns four index ranges: a first read, a later read, a first write and a later write. A burst can therefore open with a longer sequence and continue with a shorter one. A continuing request falls back to the first-access range if the previous access went to a different chip select or in the other direction. Each chip select also sets a gap of idle clocks that is inserted after each of its accesses. A request is accepted only while the engine is idle. The engine then walks its range and pulses `done` with the gathered read data.

Top module: `xbus_seq`

## Requirements
- R1: While reset is held and while the engine is idle, `ready` is 1, `done` is 0, `cs_pin` is 1, `clk_gate` is 0, `dq_oe` and `grp_is_addr` are 0, and `ctl_out` equals `ctl_invert`.
- R2: A table word is 34 bits wide. Bits [7:0] hold the segment length and bit 8 the CS level. Bit 9 is the clock gate. Bits [13:10] hold the per-group address select (group g at bit 10+g), bits [17:14] the per-group drive enable (group g at bit 14+g), bits [25:18] the lane source (2 bits per group, group g at 18+2g) and bits [33:26] the control levels. During a segment, `cs_pin`, `clk_gate`, `grp_is_addr` and `dq_oe` show the word's fields.
- R3: A segment lasts its length field in clocks. A length of 0 lasts 1 clock.
- R4: After an accepted request, the first segment appears on the pins in the clock after the accepting edge. Segments run from the range's first index to its last index inclusive, stepping by one and wrapping from 63 to 0. `done` is high for exactly the one clock after the last segment.
- R5: The range is chosen by kind = {write, continuing}: 0 first read, 1 later read, 2 first write, 3 later write. The range register is loaded through `rng_cs` and `rng_kind`.
- R6: A continuing request uses the later-access range only if the previous accepted access used the same chip select and the same direction. Otherwise it uses the first-access range.
- R7: A driven byte group g outputs byte `src[g]` of the latched address when its address select is set, and of the latched write data otherwise.
- R8: `rd_data` is cleared when a request is accepted. Byte group g of `dq_in` is captured on the last clock of every segment whose drive enable and address select are both 0 for g.
- R9: After `done`, `ready` stays low for the chip select's gap count in clocks, including the `done` clock.
- R10: Requests presented while the engine is busy are ignored. The access in flight keeps the address, data, chip select and direction that were latched when it was accepted.
- R11: `ctl_out` is each control level XOR `ctl_invert`, and `ctl_oe` equals `ctl_drive`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Write strobe for the segment table |
| tbl_idx | input | 6 | Table index to write |
| tbl_word | input | 34 | Segment word to write |
| rng_we | input | 1 | Write strobe for one index range |
| rng_cs | input | 2 | Chip select of the range |
| rng_kind | input | 2 | Range kind {write, continuing} |
| rng_first | input | 6 | First table index of the range |
| rng_last | input | 6 | Last table index of the range |
| gap_we | input | 1 | Write strobe for a gap count |
| gap_cs | input | 2 | Chip select of the gap count |
| gap_len | input | 8 | Idle clocks after each access |
| ctl_invert | input | 8 | Per-line control polarity |
| ctl_drive | input | 8 | Per-line control direction |
| req_valid | input | 1 | Access request |
| req_cs | input | 2 | Chip select of the request |
| req_write | input | 1 | 1 write, 0 read |
| req_cont | input | 1 | Continuing beat of a burst |
| req_addr | input | 32 | Access address |
| req_wdata | input | 32 | Write data |
| ready | output | 1 | Engine idle, request will be taken |
| done | output | 1 | One-clock access completion pulse |
| rd_data | output | 32 | Gathered read data |
| cs_pin | output | 1 | Chip-select pin level |
| clk_gate | output | 1 | Bus clock enable for the segment |
| ctl_out | output | 8 | Control line levels |
| ctl_oe | output | 8 | Control line output enables |
| grp_is_addr | output | 4 | Per-group address/data function |
| dq_oe | output | 4 | Per-group DQ output enable |
| dq_out | output | 32 | DQ output value |
| dq_in | input | 32 | DQ sampled value |

## Verification
A wrong index or a wrong segment counter shows up as a wrong pin pattern within one clock of the faulty step, because every clock of every segment is compared against the word the bench wrote. A wrong range choice or wrong continuation tracking shows on the first segment of the access. A lost capture or a wrong gap count shows at `rd_data` when `done` pulses, or as `ready` rising early or late. A latch that follows the port during a busy access shows as a wrong DQ byte on the next driven segment.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  localparam int NGRP   = 4;
  localparam int BYTE_W = 8;
  localparam int DQ_W   = NGRP * BYTE_W;
  localparam int NCTRL  = 8;
  localparam int DUR_W  = 8;
  localparam int SRC_W  = $clog2(NGRP);
  localparam int KIND_N = 4;

  // Packed MSB first: control levels sit at the top, duration at the bottom.
  typedef struct packed {
    logic [NCTRL-1:0]           ctl;
    logic [NGRP-1:0][SRC_W-1:0] src;
    logic [NGRP-1:0]            drv;
    logic [NGRP-1:0]            isadr;
    logic                       clk_en;
    logic                       cs_lvl;
    logic [DUR_W-1:0]           dur;
  } seg_word_t;

  localparam int SEG_W = $bits(seg_word_t);

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_GAP  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/pbs_cmd_table.sv
module pbs_cmd_table #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 34,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pbs_range_regs.sv
module pbs_range_regs import pbs_pkg::*; #(
  parameter int CS_NUM = 4,
  parameter int IDX_W  = 6,
  parameter int GAP_W  = 8,
  parameter int CS_W   = $clog2(CS_NUM)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rng_we,
  input  logic [CS_W-1:0]  rng_cs,
  input  logic [1:0]       rng_kind,
  input  logic [IDX_W-1:0] rng_first,
  input  logic [IDX_W-1:0] rng_last,
  input  logic             gap_we,
  input  logic [CS_W-1:0]  gap_cs,
  input  logic [GAP_W-1:0] gap_len,
  input  logic [CS_W-1:0]  lk_cs,
  input  logic [1:0]       lk_kind,
  output logic [IDX_W-1:0] lk_first,
  output logic [IDX_W-1:0] lk_last,
  input  logic [CS_W-1:0]  gl_cs,
  output logic [GAP_W-1:0] gl_len
);
  localparam int NRNG = CS_NUM * KIND_N;

  logic [IDX_W-1:0] first_q [NRNG];
  logic [IDX_W-1:0] last_q  [NRNG];
  logic [GAP_W-1:0] gap_q   [CS_NUM];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NRNG; i++) begin
        first_q[i] <= '0;
        last_q[i]  <= '0;
      end
    end else if (rng_we) begin
      first_q[{rng_cs, rng_kind}] <= rng_first;
      last_q[{rng_cs, rng_kind}]  <= rng_last;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CS_NUM; i++) gap_q[i] <= '0;
    end else if (gap_we) begin
      gap_q[gap_cs] <= gap_len;
    end
  end

  assign lk_first = first_q[{lk_cs, lk_kind}];
  assign lk_last  = last_q[{lk_cs, lk_kind}];
  assign gl_len   = gap_q[gl_cs];
endmodule

// File: rtl/pbs_lane_mux.sv
module pbs_lane_mux import pbs_pkg::*; (
  input  seg_word_t         word,
  input  logic [DQ_W-1:0]   addr,
  input  logic [DQ_W-1:0]   wdata,
  output logic [DQ_W-1:0]   dq
);
  for (genvar g = 0; g < NGRP; g++) begin : g_lane
    logic [DQ_W-1:0] pick;
    assign pick = word.isadr[g] ? addr : wdata;
    assign dq[g*BYTE_W +: BYTE_W] = pick[word.src[g]*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq import pbs_pkg::*; #(
  parameter int CS_NUM    = 4,
  parameter int TBL_DEPTH = 64,
  parameter int GAP_W     = 8,
  parameter int IDX_W     = $clog2(TBL_DEPTH),
  parameter int CS_W      = $clog2(CS_NUM)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_idx,
  input  logic [SEG_W-1:0]  tbl_word,
  input  logic              rng_we,
  input  logic [CS_W-1:0]   rng_cs,
  input  logic [1:0]        rng_kind,
  input  logic [IDX_W-1:0]  rng_first,
  input  logic [IDX_W-1:0]  rng_last,
  input  logic              gap_we,
  input  logic [CS_W-1:0]   gap_cs,
  input  logic [GAP_W-1:0]  gap_len,
  input  logic [NCTRL-1:0]  ctl_invert,
  input  logic [NCTRL-1:0]  ctl_drive,
  input  logic              req_valid,
  input  logic [CS_W-1:0]   req_cs,
  input  logic              req_write,
  input  logic              req_cont,
  input  logic [DQ_W-1:0]   req_addr,
  input  logic [DQ_W-1:0]   req_wdata,
  output logic              ready,
  output logic              done,
  output logic [DQ_W-1:0]   rd_data,
  output logic              cs_pin,
  output logic              clk_gate,
  output logic [NCTRL-1:0]  ctl_out,
  output logic [NCTRL-1:0]  ctl_oe,
  output logic [NGRP-1:0]   grp_is_addr,
  output logic [NGRP-1:0]   dq_oe,
  output logic [DQ_W-1:0]   dq_out,
  input  logic [DQ_W-1:0]   dq_in
);
  seq_state_t       state_q;
  logic [IDX_W-1:0] idx_q, end_q;
  logic [DUR_W-1:0] cnt_q;
  logic [GAP_W-1:0] gap_cnt_q;
  logic [CS_W-1:0]  cs_q, prev_cs_q;
  logic             prev_wr_q, prev_ok_q;
  logic [DQ_W-1:0]  addr_q, wdata_q;
  logic             done_q;

  logic [SEG_W-1:0] tbl_rdata;
  seg_word_t        cur;
  logic [IDX_W-1:0] rd_idx;
  logic [IDX_W-1:0] lk_first, lk_last;
  logic [GAP_W-1:0] cs_gap;
  logic             accept, cont_ok, running, seg_end, last_seg;
  logic [DUR_W-1:0] seg_top;

  assign cur     = seg_word_t'(tbl_rdata);
  assign running = (state_q == S_RUN);
  assign accept  = (state_q == S_IDLE) && req_valid;
  assign cont_ok = req_cont && prev_ok_q && (prev_cs_q == req_cs) && (prev_wr_q == req_write);
  assign seg_top = (cur.dur == '0) ? '0 : cur.dur - 1'b1;
  assign seg_end = running && (cnt_q == seg_top);
  assign last_seg = (idx_q == end_q);

  // The table is read every clock; the held index keeps the word steady.
  always_comb begin
    if (accept)                 rd_idx = lk_first;
    else if (seg_end && !last_seg) rd_idx = idx_q + 1'b1;
    else                        rd_idx = idx_q;
  end

  pbs_cmd_table #(.DEPTH(TBL_DEPTH), .WIDTH(SEG_W), .AW(IDX_W)) u_tbl (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_idx),
    .wdata (tbl_word),
    .raddr (rd_idx),
    .rdata (tbl_rdata)
  );

  pbs_range_regs #(.CS_NUM(CS_NUM), .IDX_W(IDX_W), .GAP_W(GAP_W), .CS_W(CS_W)) u_rng (
    .clk       (clk),
    .rst       (rst),
    .rng_we    (rng_we),
    .rng_cs    (rng_cs),
    .rng_kind  (rng_kind),
    .rng_first (rng_first),
    .rng_last  (rng_last),
    .gap_we    (gap_we),
    .gap_cs    (gap_cs),
    .gap_len   (gap_len),
    .lk_cs     (req_cs),
    .lk_kind   ({req_write, cont_ok}),
    .lk_first  (lk_first),
    .lk_last   (lk_last),
    .gl_cs     (cs_q),
    .gl_len    (cs_gap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      idx_q     <= '0;
      end_q     <= '0;
      cnt_q     <= '0;
      gap_cnt_q <= '0;
      cs_q      <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      prev_cs_q <= '0;
      prev_wr_q <= 1'b0;
      prev_ok_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (accept) begin
            state_q   <= S_RUN;
            idx_q     <= lk_first;
            end_q     <= lk_last;
            cnt_q     <= '0;
            cs_q      <= req_cs;
            addr_q    <= req_addr;
            wdata_q   <= req_wdata;
            prev_cs_q <= req_cs;
            prev_wr_q <= req_write;
            prev_ok_q <= 1'b1;
          end
        end
        S_RUN: begin
          if (seg_end) begin
            cnt_q <= '0;
            if (last_seg) begin
              done_q <= 1'b1;
              if (cs_gap != '0) begin
                state_q   <= S_GAP;
                gap_cnt_q <= cs_gap;
              end else begin
                state_q <= S_IDLE;
              end
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_GAP: begin
          if (gap_cnt_q <= 1) state_q <= S_IDLE;
          else                gap_cnt_q <= gap_cnt_q - 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // Per-group capture of sampled data bytes at segment end.
  logic [BYTE_W-1:0] cap_q [NGRP];
  for (genvar g = 0; g < NGRP; g++) begin : g_cap
    always_ff @(posedge clk) begin
      if (rst || accept)
        cap_q[g] <= '0;
      else if (seg_end && !cur.drv[g] && !cur.isadr[g])
        cap_q[g] <= dq_in[g*BYTE_W +: BYTE_W];
    end
    assign rd_data[g*BYTE_W +: BYTE_W] = cap_q[g];
  end

  logic [DQ_W-1:0] lane_dq;
  pbs_lane_mux u_lane (
    .word  (cur),
    .addr  (addr_q),
    .wdata (wdata_q),
    .dq    (lane_dq)
  );

  assign ready       = (state_q == S_IDLE);
  assign done        = done_q;
  assign cs_pin      = running ? cur.cs_lvl : 1'b1;
  assign clk_gate    = running & cur.clk_en;
  assign ctl_out     = (running ? cur.ctl : '0) ^ ctl_invert;
  assign ctl_oe      = ctl_drive;
  assign grp_is_addr = running ? cur.isadr : '0;
  assign dq_oe       = running ? cur.drv : '0;
  assign dq_out      = lane_dq;
endmodule

// File: rtl/pbs_check.sv
module pbs_check import pbs_pkg::*; (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             ready,
  input logic             done,
  input logic             cs_pin,
  input logic             clk_gate,
  input logic [NGRP-1:0]  dq_oe,
  input logic [NCTRL-1:0] ctl_out,
  input logic [NCTRL-1:0] ctl_invert,
  input logic [DQ_W-1:0]  rd_data
);
  p_idle_pins_r1: assert property (@(posedge clk) disable iff (rst)
    ready |-> (cs_pin && !clk_gate && dq_oe == '0 && ctl_out == ctl_invert));

  p_done_after_busy_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> !$past(ready));

  p_take_leaves_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ready) |=> !ready);

  p_rd_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (ready && $past(ready)) |-> $stable(rd_data));

  p_done_one_clock_r4: assert property (@(posedge clk) disable iff (rst)
    (done && !ready) |=> !done);
endmodule

bind xbus_seq pbs_check u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .ready      (ready),
  .done       (done),
  .cs_pin     (cs_pin),
  .clk_gate   (clk_gate),
  .dq_oe      (dq_oe),
  .ctl_out    (ctl_out),
  .ctl_invert (ctl_invert),
  .rd_data    (rd_data)
);

// File: tb/sim_xbus_seq.sv
`timescale 1ns/1ps
module sim_xbus_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  always #2 clk = ~clk;

  logic        tbl_we = 0;
  logic [5:0]  tbl_idx = 0;
  logic [33:0] tbl_word = 0;
  logic        rng_we = 0;
  logic [1:0]  rng_cs = 0, rng_kind = 0;
  logic [5:0]  rng_first = 0, rng_last = 0;
  logic        gap_we = 0;
  logic [1:0]  gap_cs = 0;
  logic [7:0]  gap_len = 0;
  logic [7:0]  ctl_invert = 0, ctl_drive = 0;
  logic        req_valid = 0, req_write = 0, req_cont = 0;
  logic [1:0]  req_cs = 0;
  logic [31:0] req_addr = 0, req_wdata = 0, dq_in = 0;
  logic        ready, done, cs_pin, clk_gate;
  logic [31:0] rd_data, dq_out;
  logic [7:0]  ctl_out, ctl_oe;
  logic [3:0]  grp_is_addr, dq_oe;

  xbus_seq u0 (.*);

  int checks = 0, errors = 0, cyc = 0;
  logic [33:0] tw [64];
  logic [5:0]  rf [4][4];
  logic [5:0]  rl [4][4];
  logic [7:0]  gp [4];
  bit pv = 0; int pcs = 0; bit pwr = 0;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  function automatic logic [33:0] mkword(int i);
    logic [33:0] w;
    w[7:0]   = (i % 5 == 4) ? 8'd5 : 8'(i % 3);
    w[8]     = (i % 4 == 3);
    w[9]     = (i / 2) % 2 == 1;
    w[13:10] = 4'((i * 5) & 15);
    w[17:14] = 4'(((i * 3) ^ 5) & 15);
    w[25:18] = 8'((i * 37) & 255);
    w[33:26] = 8'(((i * 29) ^ 165) & 255);
    return w;
  endfunction

  task automatic put_range(int c, int k, int f, int l);
    rng_we = 1; rng_cs = 2'(c); rng_kind = 2'(k); rng_first = 6'(f); rng_last = 6'(l);
    rf[c][k] = 6'(f); rl[c][k] = 6'(l);
    @(negedge clk); rng_we = 0;
  endtask

  // Full access: entry and exit on a negative clock edge.
  task automatic access(int cs, bit wr, bit cont, logic [31:0] a, logic [31:0] d, bit poke);
    bit contok; int k, idx, nseg, len, samples, expect_len, gcount;
    logic [33:0] w; logic [31:0] exp_rd, exp_dq, mask, src;
    contok = cont && pv && (pcs == cs) && (pwr == wr);
    k = (wr ? 2 : 0) + (contok ? 1 : 0);
    idx = rf[cs][k];
    req_valid = 1; req_cs = 2'(cs); req_write = wr; req_cont = cont; req_addr = a; req_wdata = d;
    @(negedge clk);
    if (poke) begin
      req_cs = 2'(cs ^ 1); req_write = ~wr; req_addr = ~a; req_wdata = ~d;
    end else req_valid = 0;
    pv = 1; pcs = cs; pwr = wr;
    exp_rd = 0; samples = 0; expect_len = 0;
    forever begin
      w = tw[idx];
      len = (w[7:0] == 0) ? 1 : int'(w[7:0]);
      expect_len += len;
      for (int c = 0; c < len; c++) begin
        chk(cs_pin == w[8] && clk_gate == w[9] && grp_is_addr == w[13:10] && dq_oe == w[17:14],
            poke ? "R10 R2 pins during busy request" : "R2 R5 R6 segment pins",
            {cs_pin, clk_gate, grp_is_addr, dq_oe}, {w[8], w[9], w[13:10], w[17:14]});
        chk(ctl_out == (w[33:26] ^ ctl_invert) && ctl_oe == ctl_drive, "R11 control polarity",
            {ctl_out, ctl_oe}, {w[33:26] ^ ctl_invert, ctl_drive});
        exp_dq = 0; mask = 0;
        for (int g = 0; g < 4; g++) begin
          src = w[10+g] ? a : d;
          exp_dq[g*8 +: 8] = src[int'(w[18+2*g +: 2])*8 +: 8];
          if (w[14+g]) mask[g*8 +: 8] = 8'hFF;
        end
        chk((dq_out & mask) == (exp_dq & mask), "R7 lane source", dq_out & mask, exp_dq & mask);
        chk(!ready && !done, "R4 busy flags", {ready, done}, 2'b00);
        samples++; cyc++;
        dq_in = 32'h9E3779B9 * cyc + 32'h1234;
        if (c == len - 1) begin
          for (int g = 0; g < 4; g++)
            if (!w[14+g] && !w[10+g]) exp_rd[g*8 +: 8] = dq_in[g*8 +: 8];
          if (idx == int'(rl[cs][k])) req_valid = 0;
        end
        @(negedge clk);
      end
      if (idx == int'(rl[cs][k])) break;
      idx = (idx + 1) % 64;
    end
    chk(samples == expect_len, "R3 R4 access length", 64'(samples), 64'(expect_len));
    chk(done == 1'b1, "R4 done pulse", 64'(done), 64'd1);
    chk(rd_data == exp_rd, "R8 read capture", rd_data, exp_rd);
    gcount = 0;
    while (!ready && gcount < 300) begin
      gcount++;
      @(negedge clk);
      chk(!done, "R4 done single clock", 64'(done), 64'd0);
    end
    chk(gcount == int'(gp[cs]), "R9 gap length", 64'(gcount), 64'(gp[cs]));
  endtask

  initial begin
    #(4 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ready && !done && cs_pin && !clk_gate && dq_oe == 0 && grp_is_addr == 0 && ctl_out == ctl_invert,
        "R1 reset pins", {ready, done, cs_pin, clk_gate, dq_oe, grp_is_addr},
        {1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 4'h0});
    rst = 0;
    @(negedge clk);
    chk(ready && cs_pin && dq_oe == 0, "R1 idle after reset", {ready, cs_pin, dq_oe}, {1'b1, 1'b1, 4'h0});
    for (int i = 0; i < 64; i++) begin
      tw[i] = mkword(i);
      tbl_we = 1; tbl_idx = 6'(i); tbl_word = tw[i];
      @(negedge clk);
    end
    tbl_we = 0;
    for (int c = 0; c < 4; c++)
      for (int k = 0; k < 4; k++)
        put_range(c, k, c * 16 + k * 4, c * 16 + k * 4 + ((k % 2 == 1) ? 1 : 3));
    for (int c = 0; c < 4; c++) begin
      gap_we = 1; gap_cs = 2'(c); gap_len = 8'(c); gp[c] = 8'(c);
      @(negedge clk);
    end
    gap_we = 0;

    // R5 R6: each chip select through first/later beats and direction swaps
    for (int c = 0; c < 4; c++) begin
      access(c, 0, 0, 32'hA1B2C3D4 + c, 32'h11223344 ^ c, 0);
      access(c, 0, 1, 32'h5566_7788 + c, 32'h99AA_BBCC, 0);
      access(c, 1, 1, 32'hDEAD_BEEF, 32'h0BAD_F00D + c, 0);
      access(c, 1, 1, 32'h0F1E_2D3C, 32'h4B5A_6978, 0);
      access(c, 0, 1, 32'hCAFE_0000 + c, 32'h1357_9BDF, 0);
    end
    // R6: continuing beat after a different chip select
    access(0, 0, 1, 32'h7654_3210, 32'hFEDC_BA98, 0);

    // R11: polarity and direction
    ctl_invert = 8'h3C; ctl_drive = 8'hA5;
    @(negedge clk);
    chk(ctl_out == 8'h3C && ctl_oe == 8'hA5, "R11 idle polarity", {ctl_out, ctl_oe}, {8'h3C, 8'hA5});
    access(1, 1, 0, 32'h8421_8421, 32'h1248_1248, 0);
    access(2, 0, 0, 32'h0000_FFFF, 32'hFFFF_0000, 0);

    // R10: request held high with changing fields while busy
    access(2, 1, 0, 32'h600D_CAFE, 32'hC0DE_D00D, 1);
    access(3, 1, 0, 32'h2468_ACE0, 32'h1357_9BDF, 1);

    // R4: range that wraps past the top index
    put_range(3, 0, 62, 1);
    access(3, 0, 0, 32'hF00D_1234, 32'h5A5A_A5A5, 0);
    access(3, 0, 0, 32'h0123_4567, 32'h89AB_CDEF, 0);

    summary();
    $finish;
  end
endmodule